// File: doc/BRIEF.md
# Lane Error Counter Bank

This block keeps four independent 16-bit error counters for the test facility of a multi-port, multi-lane serial link. Each counter is steered to one port and one lane by its own pair of select fields in a configuration register. It counts the error pulses that the pattern checker of that lane raises, but only while the device is in serial-link test mode. The pattern checkers are outside the block. Their per-cycle error flags arrive as one flattened vector.

Software reaches the bank through a simple register bus with one write strobe and one read strobe. Two 32-bit count registers each return a pair of counters. A read clears the counters it returns, in the same step. If an error arrives on the cycle of that read, the read still returns the old value and the error is kept by restarting the counter at 1. Counters stop at their maximum value rather than wrapping.

Top module: `lane_err_bank`

## Requirements
- R1: After reset every counter is 0, the configuration register is 0 and the read data output is 0.
- R2: The configuration register at address 0x0C8 can be written and read back. Counter k uses bits [8k+2:8k] as its port select and bits [8k+6:8k+4] as its lane select. A write takes effect on the cycle after the write.
- R3: A counter increments by one on a clock edge where test mode is high and the error flag for its selected port and lane is high. The flag for port p, lane l is bit p*NUM_LANES+l of the error vector.
- R4: A port select of NUM_PORTS or more, or a lane select of NUM_LANES or more, never counts. The defaults are 6 ports and 4 lanes.
- R5: Counters that select the same port and lane each count the same errors independently.
- R6: A counter at 0xFFFF stays at 0xFFFF when further errors arrive.
- R7: Reading address 0x0CC returns counter 1 in bits 31:16 and counter 0 in bits 15:0. Reading address 0x0D0 returns counter 3 and counter 2 in the same way. The data appears on the output one cycle after the read strobe. Any other address reads as 0.
- R8: A read of a count register clears both counters it returns. A counter whose error arrives on the cycle of that read returns its old value and then holds 1.
- R9: Writes to the count registers leave the counters unchanged. Changing a counter's select fields does not clear it.
- R10: While test mode is low, the counters hold their values whatever the error vector does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode_i | input | 1 | High while the device is in serial-link test mode |
| lane_err_i | input | NUM_PORTS*NUM_LANES | Per-lane error flags; bit p*NUM_LANES+l is port p, lane l |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |

## Verification
Every input drive sets the inputs for exactly one rising edge. The effect of that edge on the counters and the configuration is therefore settled before the next drive. The bench's model updates its expected counts once per drive, in step with the design. Read data is due one cycle after the strobe. The driver queues the expected word when it issues the read, and the monitor compares it at the falling edge that follows the capturing rising edge. This puts the coincident-error read and the clear it causes on the same edge, with the first count after it visible on the next read.

// File: rtl/lecb_pkg.sv
package lecb_pkg;
    localparam int NUM_CNT  = 4;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int FIELD_W  = 8;   // per-counter byte in the configuration register
    localparam logic [ADDR_W-1:0] ADDR_CFG   = 8'hC8;
    localparam logic [ADDR_W-1:0] ADDR_CNT_A = 8'hCC;
    localparam logic [ADDR_W-1:0] ADDR_CNT_B = 8'hD0;
endpackage

// File: rtl/lecb_lane_pick.sv
module lecb_lane_pick #(
    parameter int NUM_PORTS = 6,
    parameter int NUM_LANES = 4,
    parameter int SEL_W     = 3,
    localparam int NUM_ERR  = NUM_PORTS * NUM_LANES
) (
    input  logic               test_mode_i,
    input  logic [NUM_ERR-1:0] lane_err_i,
    input  logic [SEL_W-1:0]   port_sel_i,
    input  logic [SEL_W-1:0]   lane_sel_i,
    output logic               hit_o
);
    // Selections outside the populated range match no loop index and so never hit.
    always_comb begin
        hit_o = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int l = 0; l < NUM_LANES; l++) begin
                if (port_sel_i == SEL_W'(p) && lane_sel_i == SEL_W'(l))
                    hit_o = test_mode_i & lane_err_i[p*NUM_LANES+l];
            end
        end
    end
endmodule

// File: rtl/lecb_sat_counter.sv
module lecb_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)
            st_d.cnt = inc_i ? CNT_W'(1) : '0;
        else if (inc_i && st_q.cnt != CNT_MAX)
            st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !clr_i) |=> st_q.cnt == CNT_MAX);
    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && st_q.cnt != CNT_MAX) |=> st_q.cnt == $past(st_q.cnt) + CNT_W'(1));
    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !inc_i) |=> st_q.cnt == '0);
    // R8
    clear_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && inc_i) |=> st_q.cnt == CNT_W'(1));
endmodule

// File: rtl/lecb_regif.sv
module lecb_regif
    import lecb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic                     rd_en_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic [NUM_CNT*CNT_W-1:0] counts_i,
    output logic [DATA_W-1:0]        cfg_o,
    output logic [NUM_CNT-1:0]       clr_o,
    output logic [DATA_W-1:0]        rdata_o
);
    localparam int PAIR_W = 2 * CNT_W;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [PAIR_W-1:0] pair_a, pair_b;

    assign pair_a = counts_i[0 +: PAIR_W];
    assign pair_b = counts_i[PAIR_W +: PAIR_W];

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        if (wr_en_i && addr_i == ADDR_CFG)
            st_d.cfg = wdata_i;
        if (rd_en_i) begin
            unique case (addr_i)
                ADDR_CFG:   st_d.rdata = st_q.cfg;
                ADDR_CNT_A: begin
                    st_d.rdata = DATA_W'(pair_a);
                    clr_o[1:0] = 2'b11;
                end
                ADDR_CNT_B: begin
                    st_d.rdata = DATA_W'(pair_b);
                    clr_o[3:2] = 2'b11;
                end
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o   = st_q.cfg;
    assign rdata_o = st_q.rdata;

    // R9
    cfg_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i != ADDR_CFG) |=> $stable(cfg_o));
    // R7
    read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_CNT_B) |=> rdata_o == DATA_W'($past(pair_b)));
endmodule

// File: rtl/lane_err_bank.sv
module lane_err_bank
    import lecb_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int NUM_LANES = 4,
    parameter int SEL_W     = 3,
    parameter int CNT_W     = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           test_mode_i,
    input  logic [NUM_PORTS*NUM_LANES-1:0] lane_err_i,
    input  logic                           wr_en_i,
    input  logic                           rd_en_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [DATA_W-1:0]              rdata_o
);
    localparam int LANE_OFS = FIELD_W / 2;

    logic [DATA_W-1:0]        cfg;
    logic [NUM_CNT-1:0]       clr;
    logic [NUM_CNT-1:0]       hit;
    logic [NUM_CNT*CNT_W-1:0] counts;

    lecb_regif #(.CNT_W(CNT_W)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .counts_i (counts),
        .cfg_o    (cfg),
        .clr_o    (clr),
        .rdata_o  (rdata_o)
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        lecb_lane_pick #(
            .NUM_PORTS (NUM_PORTS),
            .NUM_LANES (NUM_LANES),
            .SEL_W     (SEL_W)
        ) u_pick (
            .test_mode_i (test_mode_i),
            .lane_err_i  (lane_err_i),
            .port_sel_i  (cfg[k*FIELD_W +: SEL_W]),
            .lane_sel_i  (cfg[k*FIELD_W+LANE_OFS +: SEL_W]),
            .hit_o       (hit[k])
        );

        lecb_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (hit[k]),
            .clr_i (clr[k]),
            .cnt_o (counts[k*CNT_W +: CNT_W])
        );

        // R10
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!test_mode_i && !clr[k]) |=> $stable(counts[k*CNT_W +: CNT_W]));
    end
endmodule

// File: tb/lane_err_bank_tb.sv
module lane_err_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 6;
    localparam int NL = 4;
    localparam int NE = NP * NL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_mode = 1'b0;
    logic [NE-1:0] lane_err = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;

    int checks = 0, failures = 0;
    logic rd_fire = 1'b0;

    typedef struct { logic [31:0] val; string tag; } exp_t;
    exp_t exp_q[$];

    int          mcnt[4];
    logic [31:0] mcfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_err_bank u_dut (
        .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode), .lane_err_i(lane_err),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: a read captured at a rising edge is compared at the next falling edge.
    always @(posedge clk) rd_fire <= rst_n & rd_en;
    always @(negedge clk) begin
        if (rd_fire) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard: actual=%h expected=<none>", rdata);
            end else begin
                e = exp_q.pop_front();
                check(rdata, e.val, e.tag);
            end
        end
    end

    // Driver: one call drives the inputs for one rising edge and advances the model.
    task automatic step(input logic tm, input logic [NE-1:0] err, input logic rd,
                        input logic wr, input logic [7:0] a, input logic [31:0] wd,
                        input string tag);
        exp_t e;
        @(negedge clk);
        test_mode = tm; lane_err = err; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
        if (rd) begin
            e.tag = tag;
            if (a == 8'hC8)      e.val = mcfg;
            else if (a == 8'hCC) e.val = {mcnt[1][15:0], mcnt[0][15:0]};
            else if (a == 8'hD0) e.val = {mcnt[3][15:0], mcnt[2][15:0]};
            else                 e.val = '0;
            exp_q.push_back(e);
        end
        for (int k = 0; k < 4; k++) begin
            int  p = int'(mcfg[k*8 +: 3]);
            int  l = int'(mcfg[k*8+4 +: 3]);
            logic h = tm && p < NP && l < NL && err[p*NL+l];
            logic c = rd && ((a == 8'hCC && k < 2) || (a == 8'hD0 && k >= 2));
            if (c)                       mcnt[k] = h ? 1 : 0;
            else if (h && mcnt[k] < 65535) mcnt[k]++;
        end
        if (wr && a == 8'hC8) mcfg = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, 8'h00, '0, "idle");
    endtask

    function automatic logic [NE-1:0] bit_at(input int idx);
        logic [NE-1:0] v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 300000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) mcnt[k] = 0;
        mcfg = '0;
        repeat (3) @(negedge clk);
        check(rdata, 32'h0, "R1 rdata after reset");
        rst_n = 1'b1;
        // R1: reset contents
        step(0, '0, 1, 0, 8'hCC, '0, "R1 count pair A reset");
        step(0, '0, 1, 0, 8'hD0, '0, "R1 count pair B reset");
        step(0, '0, 1, 0, 8'hC8, '0, "R1 cfg reset");
        // R2: c0,c1 -> port1 lane2 ; c2 -> port5 lane3 ; c3 -> port6 (out of range)
        step(0, '0, 0, 1, 8'hC8, 32'h16352121, "cfg write");
        step(0, '0, 1, 0, 8'hC8, '0, "R2 cfg readback");
        step(0, '0, 1, 0, 8'h40, '0, "R7 unmapped address");
        // R10: errors with test mode low
        for (int i = 0; i < 5; i++) step(0, '1, 0, 0, 8'h00, '0, "gate");
        step(0, '0, 1, 0, 8'hCC, '0, "R10 no count outside test mode");
        // R3 R5: shared selection
        for (int i = 0; i < 3; i++) step(1, bit_at(6), 0, 0, 8'h00, '0, "pulse");
        step(1, bit_at(5), 0, 0, 8'h00, '0, "neighbour lane");
        step(1, bit_at(10), 0, 0, 8'h00, '0, "neighbour port");
        // R4: all flags high, c3 has an out-of-range port
        for (int i = 0; i < 2; i++) step(1, '1, 0, 0, 8'h00, '0, "all");
        step(1, bit_at(23), 0, 0, 8'h00, '0, "pulse c2");
        step(0, '0, 1, 0, 8'hCC, '0, "R5 shared selection pair A");
        step(0, '0, 1, 0, 8'hCC, '0, "R8 pair A cleared");
        // R9: count-register writes ignored
        step(1, bit_at(23), 0, 1, 8'hD0, 32'h0, "write count reg");
        step(0, '0, 1, 0, 8'hD0, '0, "R4 R9 pair B after write");
        for (int i = 0; i < 4; i++) step(1, bit_at(23), 0, 0, 8'h00, '0, "pulse c2");
        // R9: c2 to lane 5 (out of range), c3 to port0 lane0; no clear
        step(0, '0, 0, 1, 8'hC8, 32'h00552121, "reselect");
        for (int i = 0; i < 3; i++) step(1, '1, 0, 0, 8'h00, '0, "all");
        step(0, '0, 1, 0, 8'hD0, '0, "R9 select change keeps count");
        // R6: saturation on c3
        for (int i = 0; i < 65540; i++) step(1, bit_at(0), 0, 0, 8'h00, '0, "sat");
        step(0, '0, 1, 0, 8'hCC, '0, "R3 pair A during saturation run");
        step(1, bit_at(0), 0, 0, 8'h00, '0, "sat");
        // R8: read with coincident error
        step(1, bit_at(0), 1, 0, 8'hD0, '0, "R6 saturated value read");
        step(0, '0, 1, 0, 8'hD0, '0, "R8 coincident error restarts at 1");
        step(1, bit_at(6), 1, 0, 8'hCC, '0, "R8 pair A coincident read");
        step(0, '0, 1, 0, 8'hCC, '0, "R8 pair A restart");
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule